// File: doc/BRIEF.md
# Conservative Controlled-Swap Barrel Rotator with Two-Vector Self-Test

This block rotates a 16-bit word to the left by 0 to 15 places in a single combinational pass. Every steering element in the datapath is a three-input, three-output controlled-swap cell. Its control line passes through unchanged, and its two data lines are either passed straight or exchanged. Because each such cell keeps the number of ones it receives, the whole rotator is conservative. The total number of ones on the data outputs and on all spare ("garbage") lines equals the number of ones on the data inputs, the amount bits and the tied-high constant lines. The spare lines are brought out on a port so that this balance can be observed.

The rotator is built from log2(16) = 4 stages. Stage k rotates by 2^k when amount bit k is set, and passes the word through otherwise. Each input bit of a stage feeds two cells. The bit is duplicated by a copier made from the same swap cell with its data inputs tied to 0 and 1. The copier gives two true copies and one inverted copy, so the copy step is conservative too.

A small sequencer wraps the rotator. On a start request it drives the all-zeros word and then the all-ones word through the datapath, using a fixed amount. It flags a failure if the word that comes out differs from the constant that went in, or if the ones balance does not hold. For verification, a fault port can force any one of the 80 stage-boundary data nodes to 0 or 1.

Top module: `csw_rotator_bist`

## Requirements
- R1: Outside a self-test run, `data_o` equals `data_i` rotated left by `amt_i` places. Bits that leave the most significant end re-enter at bit 0. An amount of 0 returns the word unchanged.
- R2: When the bits of `data_i` are named A (bit 15) down to P (bit 0) and the amount is 5, `data_o` reads F G ... P A B C D E. For example, 16'h8421 gives 16'h8430 and 16'hF800 gives 16'h001F.
- R3: Amount bit k alone rotates by 2^k, and the set bits add up. Every amount from 0 to 15 gives the rotation by that amount.
- R4: When no fault is injected, popcount(`data_o`) + popcount(`garbage_o`) equals popcount(rotator data input) + popcount(rotator amount) + 64.
- R5: `garbage_o` holds one 33-bit field per stage. Stage k's field starts at bit 33k. Within a field, bits [15:0] are the unselected swap outputs, bits [31:16] are the inverted copies of that stage's input word, and bit 32 is amount bit k passed through. Stage 0 therefore shows ~`data_i` in [31:16]. When amount bit 0 is clear, [15:0] holds `data_i` rotated left by 1.
- R6: A start request seen at a clock edge while the sequencer is idle or done applies the all-zeros vector in the next cycle and the all-ones vector in the cycle after that. `bist_done_o` then rises and stays high until the next start. `bist_fail_o` is 0 for a fault-free datapath.
- R7: Forcing any single node k*16+i to a constant 0 or 1 makes `bist_fail_o` read 1 at the end of a run. Node k = 0 is the rotator input word, k = 4 is the output word, and k = 1..3 are the words between stages.
- R8: During the two vector cycles, `data_o` carries the applied constant (16'h0000, then 16'hFFFF) whatever `data_i` and `amt_i` hold.
- R9: Reset is synchronous and active low. After a clock edge with `rst_n` low, `bist_done_o` and `bist_fail_o` are 0 and the block is back in mission mode, even in the middle of a run.
- R10: In the cycle after a start is accepted, `bist_done_o` and `bist_fail_o` are both 0, even if the previous run failed.
- R11: While `flt_en_i` is 0, `flt_node_i` and `flt_val_i` have no effect on `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the self-test sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 16 | Word to rotate in mission mode |
| amt_i | input | 4 | Left-rotate amount in mission mode |
| data_o | output | 16 | Rotated word (combinational) |
| garbage_o | output | 132 | Spare lines of all four stages, 33 bits per stage |
| bist_start_i | input | 1 | Request a two-vector self-test run |
| bist_done_o | output | 1 | Self-test run complete |
| bist_fail_o | output | 1 | Self-test detected a mismatch |
| flt_en_i | input | 1 | Enable stuck-at injection (verification only) |
| flt_node_i | input | 7 | Index of the node to force |
| flt_val_i | input | 1 | Value forced on the selected node |

## Verification
The rotation path and the self-test sequencer share the rotator in the same cycle. While a run is in progress, the sequencer's constant vectors must win over whatever mission word and amount are present on the inputs. The bench provokes this by holding a non-constant `data_i` and a non-zero `amt_i` throughout every run. It then judges `data_o` in each vector cycle against the pure constant and judges the final verdict. A second overlap comes from a forced stuck node sitting in the datapath while the self-test runs. Every one of the 160 node/value cases must end with the fail flag set, and a clean run that follows must clear it.

// File: rtl/csw_rot_pkg.sv
// Package: shared types for the controlled-swap rotator and its self-test.
// Assumes: nothing beyond a 1800-2017 compiler.
package csw_rot_pkg;

    // Self-test sequencer phases, in the order they are visited
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ZERO = 2'd1,
        ST_ONE  = 2'd2,
        ST_DONE = 2'd3
    } bist_state_e;

    localparam int DEF_WIDTH = 16;

endpackage

// File: rtl/csw_cell.sv
// Module: csw_cell
// A three-line controlled-swap cell. The control passes through; when the
// control is 1 the two data lines are exchanged, otherwise they pass straight.
// The number of ones at the outputs always equals the number at the inputs.
// Assumes: purely combinational use.
module csw_cell (
    input  logic ctl_i,
    input  logic a_i,
    input  logic b_i,
    output logic ctl_o,
    output logic x_o,
    output logic y_o
);

    // Pass control, steer data by control
    assign ctl_o = ctl_i;
    assign x_o   = ctl_i ? b_i : a_i;
    assign y_o   = ctl_i ? a_i : b_i;

endmodule

// File: rtl/csw_copier.sv
// Module: csw_copier
// Duplicates one bit with a controlled-swap cell whose data lines are tied to
// 0 and 1. It gives two true copies and one inverted copy, so the duplication
// stays conservative (ones in = src + 1 = ones out).
// Assumes: the inverted copy is a spare line and is brought out by the caller.
module csw_copier (
    input  logic src_i,
    output logic copy_a_o,
    output logic copy_b_o,
    output logic inv_o
);

    // Swap cell with constant data lines acts as a conservative fan-out
    csw_cell u_cell (
        .ctl_i (src_i),
        .a_i   (1'b0),
        .b_i   (1'b1),
        .ctl_o (copy_a_o),
        .x_o   (copy_b_o),
        .y_o   (inv_o)
    );

endmodule

// File: rtl/csw_rot_stage.sv
// Module: csw_rot_stage
// One rotate stage: a left rotation by SHIFT places when ctl_i is 1, a
// pass-through otherwise. Each input bit is copied, then one swap cell per
// output bit picks its own bit or the bit SHIFT places below it. The control
// line ripples through the swap cells and leaves at the top of g_o.
// g_o layout: [W-1:0] unselected swap outputs, [2W-1:W] inverted copies,
// [2W] control passed through.
// Assumes: 0 < SHIFT < W.
module csw_rot_stage #(
    parameter int W     = 16,
    parameter int SHIFT = 1
) (
    input  logic [W-1:0]   d_i,
    input  logic           c_i,
    output logic [W-1:0]   d_o,
    output logic [2*W:0]   g_o
);

    logic [W-1:0] cp_a;
    logic [W-1:0] cp_b;
    logic [W-1:0] cp_n;
    logic [W-1:0] swap_g;
    logic [W:0]   chain;

    // Control enters the ripple chain at cell 0
    assign chain[0] = c_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int SRC = (i + W - SHIFT) % W;

        csw_copier u_fo (
            .src_i    (d_i[i]),
            .copy_a_o (cp_a[i]),
            .copy_b_o (cp_b[i]),
            .inv_o    (cp_n[i])
        );

        csw_cell u_sw (
            .ctl_i (chain[i]),
            .a_i   (cp_a[i]),
            .b_i   (cp_b[SRC]),
            .ctl_o (chain[i+1]),
            .x_o   (d_o[i]),
            .y_o   (swap_g[i])
        );
    end

    // Gather every spare line of the stage
    assign g_o = {chain[W], cp_n, swap_g};

endmodule

// File: rtl/csw_rotator.sv
// Module: csw_rotator
// Combinational left rotator of log2(W) conservative stages; stage k rotates
// by 2^k under amt_i[k]. Stage-boundary words can be forced for fault
// injection: node k*W+i is bit i of the word entering stage k (k = STAGES is
// the output word).
// Assumes: W is a power of two.
module csw_rotator #(
    parameter int W = 16,
    localparam int STAGES = $clog2(W),
    localparam int G      = 2*W + 1,
    localparam int NODE_W = $clog2((STAGES+1)*W)
) (
    input  logic [W-1:0]        data_i,
    input  logic [STAGES-1:0]   amt_i,
    input  logic                flt_en_i,
    input  logic [NODE_W-1:0]   flt_node_i,
    input  logic                flt_val_i,
    output logic [W-1:0]        data_o,
    output logic [STAGES*G-1:0] garb_o
);

    logic [STAGES:0][W-1:0] raw;
    logic [STAGES:0][W-1:0] tap;

    // Rotator input word is the first boundary
    assign raw[0] = data_i;

    // Fault override on every boundary node
    for (genvar k = 0; k <= STAGES; k++) begin : g_node
        for (genvar i = 0; i < W; i++) begin : g_b
            assign tap[k][i] = (flt_en_i && (flt_node_i == NODE_W'(k*W + i)))
                               ? flt_val_i : raw[k][i];
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        csw_rot_stage #(
            .W     (W),
            .SHIFT (1 << k)
        ) u_stage (
            .d_i (tap[k]),
            .c_i (amt_i[k]),
            .d_o (raw[k+1]),
            .g_o (garb_o[k*G +: G])
        );
    end

    // Last boundary drives the result
    assign data_o = tap[STAGES];

endmodule

// File: rtl/csw_bist_seq.sv
// Module: csw_bist_seq
// Two-vector self-test sequencer. A start in idle or done clears the verdict,
// then drives all zeros for one cycle and all ones for one cycle, folding the
// datapath error flag into the verdict at each of those edges.
// Assumes: err_i is valid in the same cycle as the vector it judges.
module csw_bist_seq
    import csw_rot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic err_i,
    output logic drive_en_o,
    output logic drive_ones_o,
    output logic done_o,
    output logic fail_o
);

    bist_state_e state;

    // Phase advance and verdict accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            fail_o <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        state  <= ST_ZERO;
                        fail_o <= 1'b0;
                    end
                end
                ST_ZERO: begin
                    fail_o <= fail_o | err_i;
                    state  <= ST_ONE;
                end
                ST_ONE: begin
                    fail_o <= fail_o | err_i;
                    state  <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decoded phase outputs
    assign drive_en_o   = (state == ST_ZERO) || (state == ST_ONE);
    assign drive_ones_o = (state == ST_ONE);
    assign done_o       = (state == ST_DONE);

    // R10: an accepted start leaves done and fail low in the next cycle
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (state == ST_IDLE || state == ST_DONE)) |=> (!done_o && !fail_o));

    // R6: done only ever rises out of the all-ones phase
    a_r6_done_after_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(drive_ones_o));

    // R6: the zeros phase is always followed by the ones phase
    a_r6_zero_then_one: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && !drive_ones_o) |=> (drive_en_o && drive_ones_o));

endmodule

// File: rtl/csw_rotator_bist.sv
// Module: csw_rotator_bist
// Top: conservative rotator plus two-vector self-test. In mission mode the
// rotator sees data_i/amt_i; during a run it sees the sequencer's constant
// and BIST_AMT. A run fails if the output word differs from the constant or
// the ones balance (outputs plus spare lines vs. inputs plus amount plus the
// tied-high lines) does not hold.
// Assumes: flt_* is tied low outside verification builds.
module csw_rotator_bist #(
    parameter int WIDTH    = csw_rot_pkg::DEF_WIDTH,
    parameter int BIST_AMT = 5,
    localparam int STAGES  = $clog2(WIDTH),
    localparam int G       = 2*WIDTH + 1,
    localparam int GARB_W  = STAGES*G,
    localparam int NODE_W  = $clog2((STAGES+1)*WIDTH),
    localparam int CNT_W   = $clog2(WIDTH + GARB_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  data_i,
    input  logic [STAGES-1:0] amt_i,
    output logic [WIDTH-1:0]  data_o,
    output logic [GARB_W-1:0] garbage_o,
    input  logic              bist_start_i,
    output logic              bist_done_o,
    output logic              bist_fail_o,
    input  logic              flt_en_i,
    input  logic [NODE_W-1:0] flt_node_i,
    input  logic              flt_val_i
);

    localparam logic [STAGES-1:0] TEST_AMT = STAGES'(BIST_AMT);

    logic              drive_en;
    logic              drive_ones;
    logic [WIDTH-1:0]  core_data;
    logic [STAGES-1:0] core_amt;
    logic [CNT_W-1:0]  cnt_in;
    logic [CNT_W-1:0]  cnt_out;
    logic              obs_err;
    logic [STAGES-1:0] ctl_seen;

    // Input select: test constants override mission inputs during a run
    assign core_data = drive_en ? {WIDTH{drive_ones}} : data_i;
    assign core_amt  = drive_en ? TEST_AMT : amt_i;

    csw_rotator #(
        .W (WIDTH)
    ) u_rot (
        .data_i     (core_data),
        .amt_i      (core_amt),
        .flt_en_i   (flt_en_i),
        .flt_node_i (flt_node_i),
        .flt_val_i  (flt_val_i),
        .data_o     (data_o),
        .garb_o     (garbage_o)
    );

    // Ones entering the datapath, counting the tied-high copier lines
    always_comb begin
        cnt_in = CNT_W'(STAGES*WIDTH);
        for (int i = 0; i < WIDTH; i++)  cnt_in = cnt_in + CNT_W'(core_data[i]);
        for (int i = 0; i < STAGES; i++) cnt_in = cnt_in + CNT_W'(core_amt[i]);
    end

    // Ones leaving the datapath on result and spare lines
    always_comb begin
        cnt_out = '0;
        for (int i = 0; i < WIDTH; i++)  cnt_out = cnt_out + CNT_W'(data_o[i]);
        for (int i = 0; i < GARB_W; i++) cnt_out = cnt_out + CNT_W'(garbage_o[i]);
    end

    // Datapath verdict for the vector currently applied
    assign obs_err = (data_o != {WIDTH{drive_ones}}) || (cnt_in != cnt_out);

    csw_bist_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (bist_start_i),
        .err_i        (obs_err),
        .drive_en_o   (drive_en),
        .drive_ones_o (drive_ones),
        .done_o       (bist_done_o),
        .fail_o       (bist_fail_o)
    );

    // Control pass-through taps of each stage's spare field
    for (genvar k = 0; k < STAGES; k++) begin : g_ctl
        assign ctl_seen[k] = garbage_o[k*G + 2*WIDTH];
    end

    // Reference rotation used only by the checks below
    function automatic logic [WIDTH-1:0] ref_rotl(input logic [WIDTH-1:0] d,
                                                   input logic [STAGES-1:0] s);
        logic [2*WIDTH-1:0] t;
        t = {d, d} << s;
        return t[2*WIDTH-1:WIDTH];
    endfunction

    // R1: fault-free output is the left rotation of the applied word
    a_r1_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en_i |-> (data_o == ref_rotl(core_data, core_amt)));

    // R4: ones balance across the whole conservative structure
    a_r4_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en_i |-> (cnt_in == cnt_out));

    // R5: each stage passes its amount bit to its spare field
    a_r5_ctl_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en_i |-> (ctl_seen == core_amt));

    // R8: during the ones phase the result is all ones
    a_r8_ones_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_en_i && drive_ones) |-> (data_o == {WIDTH{1'b1}}));

endmodule

// File: tb/tb_csw_rotator_bist.sv
// Bench for csw_rotator_bist: a rotate table, an amount sweep, then directed
// reset, self-test and fault-injection runs.
module tb_csw_rotator_bist;

    localparam int W = 16;
    localparam int GW = 132;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  data_i = '0;
    logic [3:0]    amt_i = '0;
    logic [W-1:0]  data_o;
    logic [GW-1:0] garbage_o;
    logic          bist_start_i = 1'b0;
    logic          bist_done_o;
    logic          bist_fail_o;
    logic          flt_en_i = 1'b0;
    logic [6:0]    flt_node_i = '0;
    logic          flt_val_i = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    csw_rotator_bist dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_i       (data_i),
        .amt_i        (amt_i),
        .data_o       (data_o),
        .garbage_o    (garbage_o),
        .bist_start_i (bist_start_i),
        .bist_done_o  (bist_done_o),
        .bist_fail_o  (bist_fail_o),
        .flt_en_i     (flt_en_i),
        .flt_node_i   (flt_node_i),
        .flt_val_i    (flt_val_i)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // {data, amount, expected}
    localparam logic [35:0] TBL [10] = '{
        {16'h0001, 4'd1,  16'h0002},
        {16'h8000, 4'd1,  16'h0001},
        {16'h1234, 4'd4,  16'h2341},
        {16'h1234, 4'd8,  16'h3412},
        {16'hABCD, 4'd0,  16'hABCD},
        {16'h8001, 4'd15, 16'hC000},
        {16'hF0F0, 4'd12, 16'h0F0F},
        {16'h1234, 4'd12, 16'h4123},
        {16'h8421, 4'd5,  16'h8430},
        {16'hF800, 4'd5,  16'h001F}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rotl(input logic [W-1:0] d, input int s);
        logic [2*W-1:0] t;
        t = {d, d} << s;
        return t[2*W-1:W];
    endfunction

    function automatic int pop(input logic [191:0] v);
        int n = 0;
        for (int i = 0; i < 192; i++) n += int'(v[i]);
        return n;
    endfunction

    // One self-test run with mission inputs held at non-constant values
    task automatic run_bist(input bit exp_fail, input string req);
        @(negedge clk);
        data_i = 16'h5A3C;
        amt_i = 4'd3;
        bist_start_i = 1'b1;
        @(negedge clk);
        bist_start_i = 1'b0;
        #2;
        chk(!bist_done_o && !bist_fail_o, "R10 cleared after start",
            {bist_done_o, bist_fail_o}, 0);
        if (!flt_en_i) chk(data_o == 16'h0000, "R8 zeros vector", data_o, 16'h0000);
        @(negedge clk);
        #2;
        if (!flt_en_i) chk(data_o == 16'hFFFF, "R8 ones vector", data_o, 16'hFFFF);
        chk(!bist_done_o, "R6 not done in ones phase", bist_done_o, 0);
        @(negedge clk);
        #2;
        chk(bist_done_o, "R6 done after two vectors", bist_done_o, 1);
        chk(bist_fail_o == exp_fail, req, bist_fail_o, exp_fail);
    endtask

    initial begin
        // R9: reset state
        repeat (2) @(negedge clk);
        #2;
        chk(!bist_done_o && !bist_fail_o, "R9 reset state", {bist_done_o, bist_fail_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: table walk
        foreach (TBL[n]) begin
            @(negedge clk);
            data_i = TBL[n][35:20];
            amt_i = TBL[n][19:16];
            #2;
            chk(data_o == TBL[n][15:0], (amt_i == 4'd5) ? "R2 amount-5 example" : "R1 table",
                data_o, TBL[n][15:0]);
        end

        // R3/R4/R5: sweep of all amounts
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            data_i = 16'hB38E ^ 16'(s * 16'h1111);
            amt_i = 4'(s);
            #2;
            chk(data_o == rotl(data_i, s), "R3 amount sweep", data_o, rotl(data_i, s));
            chk(pop(192'(data_o)) + pop(192'(garbage_o)) == pop(192'(data_i)) + pop(192'(amt_i)) + 64,
                "R4 ones balance", pop(192'(data_o)) + pop(192'(garbage_o)),
                pop(192'(data_i)) + pop(192'(amt_i)) + 64);
            for (int k = 0; k < 4; k++)
                chk(garbage_o[k*33 + 32] == amt_i[k], "R5 control pass-through",
                    garbage_o[k*33 + 32], amt_i[k]);
            chk(garbage_o[31:16] == ~data_i, "R5 inverted copies", garbage_o[31:16], ~data_i);
            if (!amt_i[0])
                chk(garbage_o[15:0] == rotl(data_i, 1), "R5 unselected swap lines",
                    garbage_o[15:0], rotl(data_i, 1));
        end

        // R11: fault select ignored while injection disabled
        @(negedge clk);
        flt_node_i = 7'd70;
        flt_val_i = 1'b1;
        data_i = 16'h0000;
        amt_i = 4'd7;
        #2;
        chk(data_o == 16'h0000, "R11 fault port idle", data_o, 16'h0000);

        // R6: fault-free run
        run_bist(1'b0, "R6 clean verdict");

        // R7: every node, both stuck values, then R10 recovery
        for (int nd = 0; nd < 80; nd++) begin
            for (int v = 0; v < 2; v++) begin
                @(negedge clk);
                flt_en_i = 1'b1;
                flt_node_i = 7'(nd);
                flt_val_i = v[0];
                run_bist(1'b1, "R7 stuck node detected");
            end
        end
        @(negedge clk);
        flt_en_i = 1'b0;
        run_bist(1'b0, "R10 clean rerun after failure");

        // R9: reset in the middle of a run
        @(negedge clk);
        bist_start_i = 1'b1;
        @(negedge clk);
        bist_start_i = 1'b0;
        rst_n = 1'b0;
        data_i = 16'h8421;
        amt_i = 4'd5;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!bist_done_o && !bist_fail_o, "R9 mid-run reset flags",
            {bist_done_o, bist_fail_o}, 0);
        chk(data_o == 16'h8430, "R9 mission mode after reset", data_o, 16'h8430);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule